// File: doc/BRIEF.md
# ATM Connection Hash Lookup Engine

This block maps the header of an arriving ATM cell to its connection record. It folds the VPI and VCI fields into a hash index. It adds four times that index to a programmable table base to find a chain-head pointer. It then follows a singly linked list of buckets in memory. At each bucket it applies the bucket's mask to the cell header and compares the result with the bucket's stored header word.

A lookup ends with a one-cycle `done` pulse. On a hit it returns a connection pointer. For an ordinary connection this is a word fetched from the bucket. For a segmented connection that carries a message identifier, the pointer is computed from the bucket address and the identifier. On a miss, the engine increments an error count kept in the word at the table base, using a read-modify-write.

All memory traffic goes through one 32-bit port. That port has a single outstanding access, a valid/ready request and a data-valid response with any latency. Configuration is sampled when a lookup starts.

Top module: `atm_hash_lookup`

## Requirements
- R1: The cell header holds VPI in bits 27:20 and VCI in bits 19:4. For a table size of 0 to 13, the index is ({VPI[7:0],VCI[15:12]} XOR VCI[11:0]) AND (2^size − 1). The first memory read of a lookup is at base + 4·index.
- R2: For a table size of 14 (and 15, which behaves as 14), the index is {VPI[7:0],VCI[15:14],0000} XOR VCI[13:0]. The first read is at base + 4·index.
- R3: A bucket at address B holds NEXT at B, the connection word at B+4, MASK at B+8 and HEADER at B+12. The bucket matches when (MASK AND cell header) equals HEADER, over all 32 bits.
- R4: Buckets are examined in list order, following NEXT. The first matching bucket in the chain is the one used.
- R5: On a hit with the segmented-connection flag clear, `hit`=1 and `vcc_ptr` equals the word at B+4 of the matching bucket.
- R6: On a hit with the segmented-connection flag set, `vcc_ptr` = B + 4 + (mid AND (2^mid_bits − 1)), and no further read is made.
- R7: A zero chain-head pointer, or a zero NEXT after a failed compare, gives `hit`=0 and `vcc_ptr`=0. In that case the word at the base address is read and written back incremented by one.
- R8: After MAX_CHAIN buckets (default 256) have failed to match, the lookup ends as a miss, as in R7. No more than MAX_CHAIN buckets are visited.
- R9: After reset, `busy`, `done`, `hit` and `vcc_ptr` are 0. `start` is accepted only when `busy` is low. `done` is high for exactly one cycle. `hit` and `vcc_ptr` stay unchanged until the next accepted `start`.
- R10: `mem_req_valid` stays high with a stable address and write flag until `mem_req_ready`. No new request is made while a read response is pending. No request is made while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a lookup (accepted when idle) |
| cell_hdr | input | 32 | Cell header, without HEC |
| is_aal34 | input | 1 | Derive the result from the message identifier |
| mid | input | MID_W | Message identifier of the cell |
| cfg_tab_size | input | 4 | Hash table size exponent, 0 to 14 |
| cfg_hash_base | input | 32 | Byte address of the hash table |
| cfg_mid_bits | input | MIDB_W | Number of significant identifier bits |
| busy | output | 1 | Lookup in progress |
| done | output | 1 | One-cycle completion pulse |
| hit | output | 1 | A matching bucket was found |
| vcc_ptr | output | 32 | Connection pointer; 0 on miss |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | Request is a write |
| mem_req_addr | output | 32 | Byte address |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |

## Verification
The index result is due on the first request after `start`, a cycle after acceptance. The bench's memory model records the address at the handshake of that first request and compares it with an index it computes arithmetically. The results are due when `done` rises. That happens one cycle after the last accepted write on a miss, or one cycle after the last read response on a hit, whatever memory latency the randomised ready and response delays produce. So the bench waits for `done` at falling edges instead of counting cycles. It then reads `hit` and `vcc_ptr`, and reads the error word in the model's memory. Stability and the one-cycle pulse are checked by sampling the falling edges after `done`.

// File: rtl/hlk_pkg.sv
package hlk_pkg;

  localparam int TS_W     = 4;
  localparam int IDX_W    = 14;
  localparam logic [31:0] OFS_NEXT = 32'd0;
  localparam logic [31:0] OFS_VCC  = 32'd4;
  localparam logic [31:0] OFS_MASK = 32'd8;
  localparam logic [31:0] OFS_HDR  = 32'd12;

  typedef enum logic [3:0] {
    ST_IDLE, ST_HEAD, ST_MASK, ST_HDR, ST_VCC, ST_NEXT, ST_ERR_RD, ST_ERR_WR, ST_DONE
  } hlk_state_e;

  // Fold VPI/VCI into the table index; sizes 14 and 15 use the wide fold.
  function automatic logic [IDX_W-1:0] hlk_hash_idx(logic [31:0] hdr, logic [TS_W-1:0] ts);
    logic [7:0]       vpi;
    logic [15:0]      vci;
    logic [11:0]      fold12;
    logic [IDX_W-1:0] keep;
    vpi = hdr[27:20];
    vci = hdr[19:4];
    if (ts >= 4'd14) begin
      return {vpi, vci[15:14], 4'b0000} ^ vci[13:0];
    end
    fold12 = {vpi, vci[15:12]} ^ vci[11:0];
    keep   = (IDX_W'(1) << ts) - IDX_W'(1);
    return {2'b00, fold12} & keep;
  endfunction

  function automatic logic [31:0] hlk_head_addr(logic [31:0] base, logic [IDX_W-1:0] idx);
    return base + {16'd0, idx, 2'b00};
  endfunction

  function automatic logic hlk_match(logic [31:0] mask, logic [31:0] stored, logic [31:0] hdr);
    return (mask & hdr) == stored;
  endfunction

  function automatic logic [31:0] hlk_seg_ptr(logic [31:0] bucket, logic [31:0] mid, logic [4:0] mbits);
    return bucket + OFS_VCC + (mid & ((32'd1 << mbits) - 32'd1));
  endfunction

endpackage

// File: rtl/hlk_index_calc.sv
module hlk_index_calc
  import hlk_pkg::*;
(
  input  logic [31:0]     hdr,
  input  logic [TS_W-1:0] tab_size,
  input  logic [31:0]     base,
  output logic [31:0]     head_addr
);
  logic [IDX_W-1:0] idx;
  always_comb begin
    idx       = hlk_hash_idx(hdr, tab_size);
    head_addr = hlk_head_addr(base, idx);
  end
endmodule

// File: rtl/hlk_bucket_cmp.sv
module hlk_bucket_cmp
  import hlk_pkg::*;
(
  input  logic [31:0] mask,
  input  logic [31:0] stored,
  input  logic [31:0] hdr,
  output logic        match
);
  always_comb match = hlk_match(mask, stored, hdr);
endmodule

// File: rtl/hlk_walk_ctrl.sv
module hlk_walk_ctrl
  import hlk_pkg::*;
#(
  parameter int MID_W     = 10,
  parameter int MIDB_W    = 4,
  parameter int MAX_CHAIN = 256,
  parameter int CNT_W     = $clog2(MAX_CHAIN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [31:0]       cell_hdr,
  input  logic              is_aal34,
  input  logic [MID_W-1:0]  mid,
  input  logic [TS_W-1:0]   cfg_tab_size,
  input  logic [31:0]       cfg_hash_base,
  input  logic [MIDB_W-1:0] cfg_mid_bits,
  input  logic [31:0]       head_addr,
  input  logic              bucket_match,
  output logic [31:0]       hdr_q,
  output logic [31:0]       mask_q,
  output logic [31:0]       base_q,
  output logic [TS_W-1:0]   ts_q,
  output logic              busy,
  output logic              done,
  output logic              hit,
  output logic [31:0]       vcc_ptr,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [31:0]       mem_req_addr,
  output logic [31:0]       mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_data,
  output logic              rsp_pending,
  output logic              chain_null,
  output logic              limit_reached,
  output logic [CNT_W-1:0]  bucket_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_CHAIN);

  hlk_state_e        state;
  logic              wait_q, aal_q, hit_q;
  logic [MID_W-1:0]  mid_q;
  logic [MIDB_W-1:0] mbits_q;
  logic [31:0]       bucket_q, err_q, vcc_q;
  logic              fire, rsp;

  always_comb begin
    unique case (state)
      ST_HEAD: mem_req_addr = head_addr;
      ST_MASK: mem_req_addr = bucket_q + OFS_MASK;
      ST_HDR:  mem_req_addr = bucket_q + OFS_HDR;
      ST_VCC:  mem_req_addr = bucket_q + OFS_VCC;
      ST_NEXT: mem_req_addr = bucket_q + OFS_NEXT;
      default: mem_req_addr = base_q;
    endcase
  end

  assign busy          = (state != ST_IDLE);
  assign done          = (state == ST_DONE);
  assign hit           = hit_q;
  assign vcc_ptr       = vcc_q;
  assign mem_req_valid = !wait_q && (state != ST_IDLE) && (state != ST_DONE);
  assign mem_req_we    = (state == ST_ERR_WR);
  assign mem_req_wdata = err_q + 32'd1;
  assign fire          = mem_req_valid && mem_req_ready;
  assign rsp           = wait_q && mem_rsp_valid;
  assign rsp_pending   = wait_q;
  assign chain_null    = rsp && ((state == ST_HEAD) || (state == ST_NEXT)) && (mem_rsp_data == 32'd0);
  assign limit_reached = rsp && (state == ST_NEXT) && (mem_rsp_data != 32'd0) && (bucket_cnt == CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      wait_q     <= 1'b0;
      hdr_q      <= '0;
      mask_q     <= '0;
      base_q     <= '0;
      ts_q       <= '0;
      aal_q      <= 1'b0;
      mid_q      <= '0;
      mbits_q    <= '0;
      bucket_q   <= '0;
      err_q      <= '0;
      vcc_q      <= '0;
      hit_q      <= 1'b0;
      bucket_cnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          hdr_q      <= cell_hdr;
          base_q     <= cfg_hash_base;
          ts_q       <= cfg_tab_size;
          aal_q      <= is_aal34;
          mid_q      <= mid;
          mbits_q    <= cfg_mid_bits;
          hit_q      <= 1'b0;
          vcc_q      <= '0;
          bucket_cnt <= '0;
          state      <= ST_HEAD;
        end
        ST_DONE: state <= ST_IDLE;
        default: begin
          if (fire) begin
            if (state == ST_ERR_WR) state <= ST_DONE;
            else                    wait_q <= 1'b1;
          end
          if (rsp) begin
            wait_q <= 1'b0;
            unique case (state)
              ST_HEAD: begin
                if (chain_null) state <= ST_ERR_RD;
                else begin
                  bucket_q   <= mem_rsp_data;
                  bucket_cnt <= CNT_W'(1);
                  state      <= ST_MASK;
                end
              end
              ST_MASK: begin
                mask_q <= mem_rsp_data;
                state  <= ST_HDR;
              end
              ST_HDR: begin
                if (bucket_match) begin
                  if (aal_q) begin
                    vcc_q <= hlk_seg_ptr(bucket_q, 32'(mid_q), 5'(mbits_q));
                    hit_q <= 1'b1;
                    state <= ST_DONE;
                  end else state <= ST_VCC;
                end else state <= ST_NEXT;
              end
              ST_VCC: begin
                vcc_q <= mem_rsp_data;
                hit_q <= 1'b1;
                state <= ST_DONE;
              end
              ST_NEXT: begin
                if (chain_null || limit_reached) state <= ST_ERR_RD;
                else begin
                  bucket_q   <= mem_rsp_data;
                  bucket_cnt <= bucket_cnt + CNT_W'(1);
                  state      <= ST_MASK;
                end
              end
              ST_ERR_RD: begin
                err_q <= mem_rsp_data;
                state <= ST_ERR_WR;
              end
              default: ;
            endcase
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/atm_hash_lookup.sv
module atm_hash_lookup
  import hlk_pkg::*;
#(
  parameter int MID_W     = 10,
  parameter int MIDB_W    = 4,
  parameter int MAX_CHAIN = 256,
  localparam int CNT_W    = $clog2(MAX_CHAIN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [31:0]       cell_hdr,
  input  logic              is_aal34,
  input  logic [MID_W-1:0]  mid,
  input  logic [3:0]        cfg_tab_size,
  input  logic [31:0]       cfg_hash_base,
  input  logic [MIDB_W-1:0] cfg_mid_bits,
  output logic              busy,
  output logic              done,
  output logic              hit,
  output logic [31:0]       vcc_ptr,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [31:0]       mem_req_addr,
  output logic [31:0]       mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_data
);
  // Named internal events, observed by the bound checker.
  logic [31:0]      hdr_q, mask_q, hash_base_q, head_addr;
  logic [TS_W-1:0]  ts_q;
  logic             bucket_match, rsp_pending, chain_null, limit_reached;
  logic [CNT_W-1:0] bucket_cnt;

  hlk_index_calc u_index (
    .hdr(hdr_q), .tab_size(ts_q), .base(hash_base_q), .head_addr(head_addr)
  );

  hlk_bucket_cmp u_cmp (
    .mask(mask_q), .stored(mem_rsp_data), .hdr(hdr_q), .match(bucket_match)
  );

  hlk_walk_ctrl #(
    .MID_W(MID_W), .MIDB_W(MIDB_W), .MAX_CHAIN(MAX_CHAIN), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .cell_hdr(cell_hdr),
    .is_aal34(is_aal34), .mid(mid), .cfg_tab_size(cfg_tab_size),
    .cfg_hash_base(cfg_hash_base), .cfg_mid_bits(cfg_mid_bits),
    .head_addr(head_addr), .bucket_match(bucket_match),
    .hdr_q(hdr_q), .mask_q(mask_q), .base_q(hash_base_q), .ts_q(ts_q),
    .busy(busy), .done(done), .hit(hit), .vcc_ptr(vcc_ptr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .rsp_pending(rsp_pending),
    .chain_null(chain_null), .limit_reached(limit_reached),
    .bucket_cnt(bucket_cnt)
  );
endmodule

// File: rtl/hlk_checker.sv
module hlk_checker #(
  parameter int MAX_CHAIN = 256,
  parameter int CNT_W     = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             hit,
  input logic [31:0]      vcc_ptr,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic             mem_req_we,
  input logic [31:0]      mem_req_addr,
  input logic [31:0]      hash_base_q,
  input logic             rsp_pending,
  input logic             limit_reached,
  input logic [CNT_W-1:0] bucket_cnt
);
  a_r10_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we));

  a_r10_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_pending |-> !mem_req_valid);

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req_valid);

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> $stable(hit) && $stable(vcc_ptr));

  a_r7_miss_null_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    done && !hit |-> vcc_ptr == 32'd0);

  a_r7_write_to_base: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_we |-> mem_req_addr == hash_base_q);

  a_r8_chain_bound: assert property (@(posedge clk) disable iff (!rst_n)
    bucket_cnt <= CNT_W'(MAX_CHAIN));

  a_r8_limit_misses: assert property (@(posedge clk) disable iff (!rst_n)
    limit_reached |=> !hit);
endmodule

bind atm_hash_lookup hlk_checker #(.MAX_CHAIN(MAX_CHAIN), .CNT_W(CNT_W)) u_hlk_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .hit(hit),
  .vcc_ptr(vcc_ptr), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr), .hash_base_q(hash_base_q),
  .rsp_pending(rsp_pending), .limit_reached(limit_reached), .bucket_cnt(bucket_cnt)
);

// File: tb/test_atm_hash_lookup.sv
module test_atm_hash_lookup;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] cell_hdr = '0;
  logic        is_aal34 = 1'b0;
  logic [9:0]  mid = '0;
  logic [3:0]  cfg_tab_size = '0;
  logic [31:0] cfg_hash_base = '0;
  logic [3:0]  cfg_mid_bits = '0;
  logic        busy, done, hit;
  logic [31:0] vcc_ptr;
  logic        mem_req_valid, mem_req_we;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;

  always #10 clk = ~clk;

  atm_hash_lookup i_atm_hash_lookup (
    .clk(clk), .rst_n(rst_n), .start(start), .cell_hdr(cell_hdr), .is_aal34(is_aal34),
    .mid(mid), .cfg_tab_size(cfg_tab_size), .cfg_hash_base(cfg_hash_base),
    .cfg_mid_bits(cfg_mid_bits), .busy(busy), .done(done), .hit(hit), .vcc_ptr(vcc_ptr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Memory model: 128 KiB of words, random ready and response delay.
  logic [31:0] mem [0:32767];
  logic [15:0] lfsr = 16'hACE1;
  bit          pend = 1'b0;
  int          dly = 0;
  logic [14:0] paddr = '0;
  bit          first_flag = 1'b0;
  logic [31:0] first_addr = '0;
  logic [31:0] track_addr = 32'hFFFF_FFFF;
  int          track_cnt = 0;
  int          wr_cnt = 0;
  int          proto_err = 0;
  bit          stalled = 1'b0;
  logic [31:0] stall_addr = '0;

  always @(posedge clk) begin
    lfsr          <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_req_ready <= lfsr[0] | lfsr[3];
    mem_rsp_valid <= 1'b0;
    if (stalled && (!mem_req_valid || mem_req_addr != stall_addr)) proto_err++;
    if (mem_req_valid && !mem_req_ready) begin
      stalled    <= 1'b1;
      stall_addr <= mem_req_addr;
    end else stalled <= 1'b0;
    if (mem_req_valid && !busy) proto_err++;
    if (pend) begin
      if (dly == 0) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= mem[paddr];
        pend          <= 1'b0;
      end else dly <= dly - 1;
    end
    if (mem_req_valid && mem_req_ready) begin
      if (pend) proto_err++;
      if (first_flag) begin
        first_addr = mem_req_addr;
        first_flag = 1'b0;
      end
      if (mem_req_addr == track_addr) track_cnt++;
      if (mem_req_we) begin
        mem[mem_req_addr[16:2]] <= mem_req_wdata;
        wr_cnt++;
      end else begin
        pend  <= 1'b1;
        dly   <= int'(lfsr[6:5]);
        paddr <= mem_req_addr[16:2];
      end
    end
  end

  // Bench's own restatement of the index rule.
  function automatic int exp_index(input logic [31:0] h, input int ts);
    int vpi, vci, hi;
    vpi = int'((h >> 20) & 32'hFF);
    vci = int'((h >> 4) & 32'hFFFF);
    if (ts >= 14) begin
      hi = ((vpi * 4) + (vci / 16384)) * 16;
      return hi ^ (vci % 16384);
    end
    hi = (vpi * 16) + (vci / 4096);
    return (hi ^ (vci % 4096)) % (1 << ts);
  endfunction

  function automatic int widx(input logic [31:0] a);
    return int'(a[16:2]);
  endfunction

  logic        r_hit;
  logic [31:0] r_vcc;
  int          r_dones;

  task automatic lookup(input logic [31:0] h, input logic a, input logic [9:0] m, input logic [3:0] mb);
    int t;
    @(negedge clk);
    cell_hdr = h; is_aal34 = a; mid = m; cfg_mid_bits = mb;
    first_flag = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    t = 0;
    while (!done && t < 20000) begin
      @(negedge clk);
      t++;
    end
    chk(t < 20000, "R9 lookup completes", 32'(t), 32'd0);
    r_hit = hit; r_vcc = vcc_ptr; r_dones = done ? 1 : 0;
    @(negedge clk);
    if (done) r_dones++;
  endtask

  localparam logic [31:0] BASE = 32'h0000_4000;
  localparam logic [31:0] B1 = 32'h0001_8000;
  localparam logic [31:0] B2 = 32'h0001_8010;
  localparam logic [31:0] B3 = 32'h0001_8100;
  localparam logic [31:0] H1 = 32'h0123_4560;  // VPI 0x12, VCI 0x3456, index 5 at size 4

  initial begin
    for (int i = 0; i < 32768; i++) mem[i] = '0;
    cfg_hash_base = BASE;
    repeat (3) @(negedge clk);
    // R9/R10 reset state
    chk(busy == 1'b0 && done == 1'b0, "R9 reset busy/done", {30'd0, busy, done}, 32'd0);
    chk(hit == 1'b0 && vcc_ptr == 32'd0, "R9 reset result", vcc_ptr, 32'd0);
    chk(mem_req_valid == 1'b0, "R10 reset no request", {31'd0, mem_req_valid}, 32'd0);
    rst_n = 1'b1;

    // R1/R2/R7: index sweep over every table size; all chains empty
    for (int ts = 0; ts < 16; ts++) begin
      cfg_tab_size = 4'(ts);
      for (int k = 0; k < 40; k++) begin
        logic [31:0] h;
        int e;
        h = 32'(k) * 32'h9E37_79B1 ^ 32'(ts) * 32'h85EB_CA6B;
        e = exp_index(h, ts);
        mem[widx(BASE)] = 32'd0;
        lookup(h, 1'b0, 10'd0, 4'd0);
        if (ts >= 14) chk(first_addr == BASE + 32'(e) * 4, "R2 wide index address", first_addr, BASE + 32'(e) * 4);
        else          chk(first_addr == BASE + 32'(e) * 4, "R1 folded index address", first_addr, BASE + 32'(e) * 4);
        chk(r_hit == 1'b0 && r_vcc == 32'd0, "R7 empty chain miss", r_vcc, 32'd0);
        chk(mem[widx(BASE)] == 32'd1, "R7 error word incremented", mem[widx(BASE)], 32'd1);
      end
    end

    // Build a two-bucket chain at index 5, table size 4
    cfg_tab_size = 4'd4;
    mem[widx(BASE)] = 32'd0;
    mem[widx(BASE + 32'd20)] = B1;
    mem[widx(B1)]      = B2;
    mem[widx(B1 + 4)]  = 32'h0000_00A1;
    mem[widx(B1 + 8)]  = 32'hF000_0000;
    mem[widx(B1 + 12)] = 32'h3000_0000;
    mem[widx(B2)]      = 32'd0;
    mem[widx(B2 + 4)]  = 32'h0000_00B2;
    mem[widx(B2 + 8)]  = 32'h0FFF_FFF0;
    mem[widx(B2 + 12)] = H1;

    lookup(H1, 1'b0, 10'd0, 4'd0);
    chk(r_hit == 1'b1 && r_vcc == 32'hB2, "R4 second bucket after NEXT", r_vcc, 32'hB2);
    chk(r_dones == 1, "R9 done one cycle", 32'(r_dones), 32'd1);
    chk(wr_cnt == 640, "R5 hit makes no write", 32'(wr_cnt), 32'd640);

    lookup(H1 | 32'h0000_000F, 1'b0, 10'd0, 4'd0);
    chk(r_hit == 1'b1 && r_vcc == 32'hB2, "R3 masked bits ignored", r_vcc, 32'hB2);

    lookup(H1 | 32'h3000_0000, 1'b0, 10'd0, 4'd0);
    chk(r_hit == 1'b1 && r_vcc == 32'hA1, "R4 first match wins", r_vcc, 32'hA1);

    lookup(32'h0123_4660, 1'b0, 10'd0, 4'd0);  // same index 5, fails both buckets
    chk(r_hit == 1'b0 && r_vcc == 32'd0, "R7 null NEXT miss", r_vcc, 32'd0);
    chk(mem[widx(BASE)] == 32'd1, "R7 counter after chain miss", mem[widx(BASE)], 32'd1);

    lookup(32'h0123_4570, 1'b0, 10'd0, 4'd0);  // index 4, empty head
    chk(mem[widx(BASE)] == 32'd2, "R7 counter after empty head", mem[widx(BASE)], 32'd2);

    // R6: identifier-derived pointer
    lookup(H1, 1'b1, 10'h3FF, 4'd4);
    chk(r_hit == 1'b1 && r_vcc == B2 + 32'h13, "R6 mid masked to 4 bits", r_vcc, B2 + 32'h13);
    lookup(H1, 1'b1, 10'h3FF, 4'd0);
    chk(r_vcc == B2 + 32'd4, "R6 zero mid bits", r_vcc, B2 + 32'd4);
    lookup(H1, 1'b1, 10'h155, 4'd10);
    chk(r_vcc == B2 + 32'd4 + 32'h155, "R6 full mid", r_vcc, B2 + 32'd4 + 32'h155);

    // R8: circular chain at index 6
    mem[widx(BASE + 32'd24)] = B3;
    mem[widx(B3)]      = B3;
    mem[widx(B3 + 8)]  = 32'hFFFF_FFFF;
    mem[widx(B3 + 12)] = 32'd0;
    track_addr = B3 + 32'd8;
    track_cnt  = 0;
    lookup(32'h0123_4550, 1'b0, 10'd0, 4'd0);
    chk(r_hit == 1'b0 && r_vcc == 32'd0, "R8 circular chain misses", r_vcc, 32'd0);
    chk(track_cnt == 256, "R8 bucket visits bounded", 32'(track_cnt), 32'd256);
    chk(mem[widx(BASE)] == 32'd3, "R8 counter incremented", mem[widx(BASE)], 32'd3);
    track_addr = 32'hFFFF_FFFF;

    // R9: start while busy is ignored; result held afterwards
    @(negedge clk);
    cell_hdr = H1; is_aal34 = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    cell_hdr = 32'h0123_4570; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    begin
      int t = 0;
      while (!done && t < 20000) begin @(negedge clk); t++; end
    end
    chk(hit == 1'b1 && vcc_ptr == 32'hB2, "R9 start during busy ignored", vcc_ptr, 32'hB2);
    chk(mem[widx(BASE)] == 32'd3, "R9 ignored start made no miss", mem[widx(BASE)], 32'd3);
    begin
      int extra = 0;
      repeat (20) begin
        @(negedge clk);
        if (done || !hit || vcc_ptr != 32'hB2) extra++;
      end
      chk(extra == 0, "R9 result stable after done", 32'(extra), 32'd0);
    end

    chk(proto_err == 0, "R10 memory handshake rules", 32'(proto_err), 32'd0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule